// File: doc/BRIEF.md
# DS2 Overhead Persistence Monitor

This block sits behind an aligned DS2 framer and watches the overhead bits that framer pulls out of each received frame. Once per frame the framer presents the three C bits of each of the four subframes, the X/alarm bit and the reserved bit, together with a frame-done strobe. The monitor runs each of these through a persistence filter, so a status flag changes state only after its new value has been seen in a fixed number of back-to-back frames. Flags are qualified the same way in both directions.

Six flags come out. Four are loopback-request flags, one per subframe. Each one carries the tributary number it belongs to, computed from the DS2 port index. There is also a remote alarm flag, whose input polarity follows the DS1/E1 mode select, and a reserved-bit report that is only tracked in E1 mode. While the framer reports out of frame, all filter state is held at zero.

Top module: `ds2_oh_monitor`

## Requirements
- R1: A subframe shows a loopback request in a frame when its C3 differs from C1 and from C2. For subframe z, C1, C2 and C3 are c_bits_i bits 3(z-1), 3(z-1)+1 and 3(z-1)+2. Its lb_det_o bit (bit z-1) rises after 5 consecutive strobed frames with a request.
- R2: A set loopback flag falls after 5 consecutive strobed frames without a request. A frame where C1 differs from C2 counts as no request.
- R3: lb_trib_o[z-1] equals 4*y - 4 + z, where y is port_idx_i (1 to 7) and z is 1 to 4.
- R4: With e1_mode_i = 0, rai_o rises after x_bit_i is 0 in 4 consecutive strobed frames. It falls after x_bit_i is 1 in 4 consecutive strobed frames.
- R5: With e1_mode_i = 1, rai_o rises after x_bit_i is 1 in 4 consecutive strobed frames. It falls after x_bit_i is 0 in 4 consecutive strobed frames.
- R6: With e1_mode_i = 1, rsv_o takes a new rsv_bit_i value only after that value is seen in 4 consecutive strobed frames. With e1_mode_i = 0, rsv_o does not change.
- R7: A persistence count restarts when one frame breaks the run before the threshold is reached.
- R8: While oof_i is 1, every flag and count is zero and strobes have no effect. Counting starts from zero once oof_i returns to 0.
- R9: The filters advance only on clock edges where frame_done_i is 1. Each flag is updated at the edge that samples the qualifying strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_done_i | input | 1 | One-cycle strobe, overhead inputs valid |
| oof_i | input | 1 | Framer out of frame; clears and holds the filters |
| c_bits_i | input | 12 | C bits; subframe z uses bits 3(z-1) to 3(z-1)+2 (C1, C2, C3) |
| x_bit_i | input | 1 | X bit (DS1) or alarm bit (E1) |
| rsv_bit_i | input | 1 | Reserved bit |
| e1_mode_i | input | 1 | 0 selects DS1 framing, 1 selects E1 |
| port_idx_i | input | 3 | DS2 port index y, 1 to 7 |
| lb_det_o | output | 4 | Loopback request flags, bit z-1 for subframe z |
| lb_trib_o | output | 4x5 | Tributary number for each loopback flag |
| rai_o | output | 1 | Remote alarm detected |
| rsv_o | output | 1 | Filtered reserved bit |

## Verification
The bench applies run lengths from one frame to one past the threshold in both directions. An off-by-one count therefore shows up as a flag that moves a frame early or a frame late. It sweeps all eight C-bit patterns, so a design that compares C3 with only one of C1 or C2 would flag the patterns with C1 unequal to C2. It drives RAI in both modes to catch a swapped polarity, and it checks that the reserved bit stays put in DS1 mode. Runs broken by a single frame would let a filter that never resets its count set too early. Inputs held without strobes would expose a filter that counts clock cycles. A frame sequence after an out-of-frame period would reveal counts that survived it.

// File: rtl/ds2_oh_pkg.sv
package ds2_oh_pkg;
  localparam int unsigned C_PER_SUB = 3;

  typedef struct packed {
    logic c3;
    logic c2;
    logic c1;
  } cgrp_t;

  function automatic logic lb_req(input cgrp_t g);
    return (g.c1 == g.c2) && (g.c3 != g.c1);
  endfunction
endpackage

// File: rtl/persist_filter.sv
module persist_filter #(
  parameter int unsigned N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  input  logic obs_i,
  output logic flag_o
);
  localparam int unsigned CW = (N > 2) ? $clog2(N) : 1;

  logic          flag_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (adv_i) begin
      if (obs_i != flag_q) begin
        if (cnt_q == CW'(N - 1)) begin
          flag_q <= obs_i;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;  // run broken, restart
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/lb_bank.sv
module lb_bank
  import ds2_oh_pkg::*;
#(
  parameter int unsigned NUM_SUB   = 4,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned LB_FRAMES = 5,
  parameter int unsigned TRIB_W    = IDX_W + $clog2(NUM_SUB)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clr_i,
  input  logic                             adv_i,
  input  logic [C_PER_SUB*NUM_SUB-1:0]     c_bits_i,
  input  logic [IDX_W-1:0]                 port_idx_i,
  output logic [NUM_SUB-1:0]               lb_det_o,
  output logic [NUM_SUB-1:0][TRIB_W-1:0]   lb_trib_o
);
  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    cgrp_t grp;
    logic  req;

    assign grp = cgrp_t'(c_bits_i[C_PER_SUB*g +: C_PER_SUB]);
    assign req = lb_req(grp);

    persist_filter #(.N(LB_FRAMES)) i_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .adv_i  (adv_i),
      .obs_i  (req),
      .flag_o (lb_det_o[g])
    );

    assign lb_trib_o[g] = TRIB_W'(NUM_SUB) * TRIB_W'(port_idx_i)
                        - TRIB_W'(NUM_SUB) + TRIB_W'(g + 1);
  end
endmodule

// File: rtl/ds2_oh_monitor.sv
module ds2_oh_monitor
  import ds2_oh_pkg::*;
#(
  parameter int unsigned NUM_SUB    = 4,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned LB_FRAMES  = 5,
  parameter int unsigned RAI_FRAMES = 4,
  parameter int unsigned RSV_FRAMES = 4,
  localparam int unsigned TRIB_W    = IDX_W + $clog2(NUM_SUB)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           frame_done_i,
  input  logic                           oof_i,
  input  logic [C_PER_SUB*NUM_SUB-1:0]   c_bits_i,
  input  logic                           x_bit_i,
  input  logic                           rsv_bit_i,
  input  logic                           e1_mode_i,
  input  logic [IDX_W-1:0]               port_idx_i,
  output logic [NUM_SUB-1:0]             lb_det_o,
  output logic [NUM_SUB-1:0][TRIB_W-1:0] lb_trib_o,
  output logic                           rai_o,
  output logic                           rsv_o
);
  logic adv;
  logic rai_obs;

  assign adv     = frame_done_i & ~oof_i;
  assign rai_obs = e1_mode_i ? x_bit_i : ~x_bit_i;  // DS1 alarm is active low

  lb_bank #(
    .NUM_SUB   (NUM_SUB),
    .IDX_W     (IDX_W),
    .LB_FRAMES (LB_FRAMES),
    .TRIB_W    (TRIB_W)
  ) i_lb_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (oof_i),
    .adv_i      (adv),
    .c_bits_i   (c_bits_i),
    .port_idx_i (port_idx_i),
    .lb_det_o   (lb_det_o),
    .lb_trib_o  (lb_trib_o)
  );

  persist_filter #(.N(RAI_FRAMES)) i_rai_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (oof_i),
    .adv_i  (adv),
    .obs_i  (rai_obs),
    .flag_o (rai_o)
  );

  persist_filter #(.N(RSV_FRAMES)) i_rsv_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (oof_i),
    .adv_i  (adv & e1_mode_i),
    .obs_i  (rsv_bit_i),
    .flag_o (rsv_o)
  );
endmodule

// File: rtl/ds2_oh_monitor_chk.sv
module ds2_oh_monitor_chk #(
  parameter int unsigned NUM_SUB = 4,
  parameter int unsigned CW      = 12,
  parameter int unsigned TRIB_W  = 5
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           frame_done_i,
  input logic                           oof_i,
  input logic [CW-1:0]                  c_bits_i,
  input logic                           x_bit_i,
  input logic                           rsv_bit_i,
  input logic                           e1_mode_i,
  input logic [NUM_SUB-1:0]             lb_det_o,
  input logic [NUM_SUB-1:0][TRIB_W-1:0] lb_trib_o,
  input logic                           rai_o,
  input logic                           rsv_o
);
  assert_lb0_rise_on_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lb_det_o[0]) |-> $past(frame_done_i && c_bits_i[0] == c_bits_i[1]
                                 && c_bits_i[2] != c_bits_i[0]));

  assert_lb0_fall_on_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lb_det_o[0]) && !$past(oof_i)) |->
      $past(frame_done_i && !(c_bits_i[0] == c_bits_i[1] && c_bits_i[2] != c_bits_i[0])));

  for (genvar g = 1; g < NUM_SUB; g++) begin : g_trib
    assert_trib_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lb_trib_o[g] == lb_trib_o[0] + TRIB_W'(g));
  end

  assert_rai_rise_polarity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rai_o) |-> $past(frame_done_i && (e1_mode_i ? x_bit_i : !x_bit_i)));

  assert_rai_fall_polarity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rai_o) && !$past(oof_i)) |-> $past(e1_mode_i ? !x_bit_i : x_bit_i));

  assert_rsv_frozen_ds1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!e1_mode_i && !oof_i) |=> $stable(rsv_o));

  assert_rsv_follows_input_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(rsv_o) && !$past(oof_i)) |-> (rsv_o == $past(rsv_bit_i)));

  assert_oof_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oof_i |=> (lb_det_o == '0 && !rai_o && !rsv_o));

  assert_no_strobe_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_done_i && !oof_i) |=> $stable({lb_det_o, rai_o, rsv_o}));
endmodule

bind ds2_oh_monitor ds2_oh_monitor_chk #(
  .NUM_SUB (NUM_SUB),
  .CW      (ds2_oh_pkg::C_PER_SUB * NUM_SUB),
  .TRIB_W  (TRIB_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_done_i (frame_done_i),
  .oof_i        (oof_i),
  .c_bits_i     (c_bits_i),
  .x_bit_i      (x_bit_i),
  .rsv_bit_i    (rsv_bit_i),
  .e1_mode_i    (e1_mode_i),
  .lb_det_o     (lb_det_o),
  .lb_trib_o    (lb_trib_o),
  .rai_o        (rai_o),
  .rsv_o        (rsv_o)
);

// File: tb/test_ds2_oh_monitor.sv
`timescale 1ns/1ps
module test_ds2_oh_monitor;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fd = 1'b0;
  logic            oof = 1'b0;
  logic [11:0]     cb = '0;
  logic            xb = 1'b1;
  logic            rb = 1'b0;
  logic            e1 = 1'b0;
  logic [2:0]      pidx = 3'd1;
  logic [3:0]      lb;
  logic [3:0][4:0] trib;
  logic            rai;
  logic            rsv;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  ds2_oh_monitor i_ds2_oh_monitor (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frame_done_i (fd),
    .oof_i        (oof),
    .c_bits_i     (cb),
    .x_bit_i      (xb),
    .rsv_bit_i    (rb),
    .e1_mode_i    (e1),
    .port_idx_i   (pidx),
    .lb_det_o     (lb),
    .lb_trib_o    (trib),
    .rai_o        (rai),
    .rsv_o        (rsv)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input logic [11:0] c, input logic x, input logic r);
    @(negedge clk);
    cb = c; xb = x; rb = r; fd = 1'b1;
    @(negedge clk);
    fd = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr();
    @(negedge clk);
    oof = 1'b1; fd = 1'b1;
    @(negedge clk);
    fd = 1'b0;
    @(negedge clk);
    oof = 1'b0;
  endtask

  function automatic logic [11:0] put(input int z, input logic [2:0] p);
    return 12'(p) << (3 * (z - 1));
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset lb", int'(lb), 0);
    chk("R8 reset rai", int'(rai), 0);
    chk("R8 reset rsv", int'(rsv), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 tributary numbers
    for (int y = 1; y <= 7; y++) begin
      pidx = 3'(y);
      #1;
      for (int z = 1; z <= 4; z++) chk("R3 trib", int'(trib[z-1]), 4 * y - 4 + z);
    end
    pidx = 3'd1;

    // R1 set threshold per subframe
    for (int z = 1; z <= 4; z++) begin
      for (int k = 1; k <= 6; k++) begin
        clr();
        for (int i = 0; i < k; i++) frame(put(z, 3'b100), 1'b1, 1'b0);
        chk("R1 set run", int'(lb), (k >= 5) ? (1 << (z - 1)) : 0);
      end
    end

    // R1 all C patterns
    for (int p = 0; p < 8; p++) begin
      int z = (p % 4) + 1;
      clr();
      for (int i = 0; i < 5; i++) frame(put(z, 3'(p)), 1'b1, 1'b0);
      chk("R1 pattern", int'(lb), (p == 4 || p == 3) ? (1 << (z - 1)) : 0);
    end

    // R2 clear threshold
    for (int k = 1; k <= 6; k++) begin
      clr();
      for (int i = 0; i < 5; i++) frame(put(2, 3'b011), 1'b1, 1'b0);
      for (int i = 0; i < k; i++) frame(12'h000, 1'b1, 1'b0);
      chk("R2 clear run", int'(lb), (k < 5) ? 2 : 0);
    end
    clr();
    for (int i = 0; i < 5; i++) frame(put(3, 3'b100), 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) frame(put(3, 3'b001), 1'b1, 1'b0);
    chk("R2 c1!=c2 clears", int'(lb), 0);

    // R7 restart on break
    clr();
    for (int i = 0; i < 4; i++) frame(put(1, 3'b100), 1'b1, 1'b0);
    frame(12'h000, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) frame(put(1, 3'b100), 1'b1, 1'b0);
    chk("R7 broken run", int'(lb), 0);
    frame(put(1, 3'b100), 1'b1, 1'b0);
    chk("R7 full run", int'(lb), 1);
    clr();
    e1 = 1'b1;
    for (int i = 0; i < 3; i++) frame(12'h000, 1'b1, 1'b0);
    frame(12'h000, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) frame(12'h000, 1'b1, 1'b0);
    chk("R7 rai broken run", int'(rai), 0);
    e1 = 1'b0;

    // R4 DS1 polarity
    for (int k = 1; k <= 5; k++) begin
      clr();
      for (int i = 0; i < k; i++) frame(12'h000, 1'b0, 1'b0);
      chk("R4 ds1 set", int'(rai), (k >= 4) ? 1 : 0);
    end
    for (int k = 1; k <= 5; k++) begin
      clr();
      for (int i = 0; i < 4; i++) frame(12'h000, 1'b0, 1'b0);
      for (int i = 0; i < k; i++) frame(12'h000, 1'b1, 1'b0);
      chk("R4 ds1 clear", int'(rai), (k < 4) ? 1 : 0);
    end

    // R5 E1 polarity
    e1 = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      clr();
      for (int i = 0; i < k; i++) frame(12'h000, 1'b1, 1'b0);
      chk("R5 e1 set", int'(rai), (k >= 4) ? 1 : 0);
    end
    for (int k = 1; k <= 5; k++) begin
      clr();
      for (int i = 0; i < 4; i++) frame(12'h000, 1'b1, 1'b0);
      for (int i = 0; i < k; i++) frame(12'h000, 1'b0, 1'b0);
      chk("R5 e1 clear", int'(rai), (k < 4) ? 1 : 0);
    end

    // R6 reserved bit
    for (int k = 1; k <= 5; k++) begin
      clr();
      for (int i = 0; i < k; i++) frame(12'h000, 1'b0, 1'b1);
      chk("R6 rsv rise", int'(rsv), (k >= 4) ? 1 : 0);
    end
    for (int k = 1; k <= 5; k++) begin
      clr();
      for (int i = 0; i < 4; i++) frame(12'h000, 1'b0, 1'b1);
      for (int i = 0; i < k; i++) frame(12'h000, 1'b0, 1'b0);
      chk("R6 rsv fall", int'(rsv), (k < 4) ? 1 : 0);
    end
    clr();
    e1 = 1'b0;
    for (int i = 0; i < 6; i++) frame(12'h000, 1'b1, 1'b1);
    chk("R6 ds1 ignores rsv=1", int'(rsv), 0);
    e1 = 1'b1;
    for (int i = 0; i < 4; i++) frame(12'h000, 1'b0, 1'b1);
    e1 = 1'b0;
    for (int i = 0; i < 6; i++) frame(12'h000, 1'b1, 1'b0);
    chk("R6 ds1 holds rsv", int'(rsv), 1);

    // R8 out of frame
    clr();
    e1 = 1'b1;
    for (int i = 0; i < 5; i++) frame(12'h924, 1'b1, 1'b1);
    chk("R8 pre lb", int'(lb), 15);
    chk("R8 pre rai", int'(rai), 1);
    chk("R8 pre rsv", int'(rsv), 1);
    @(negedge clk);
    oof = 1'b1;
    for (int i = 0; i < 6; i++) begin
      frame(12'h924, 1'b1, 1'b1);
      chk("R8 oof lb", int'(lb), 0);
      chk("R8 oof rai", int'(rai), 0);
      chk("R8 oof rsv", int'(rsv), 0);
    end
    oof = 1'b0;
    for (int i = 0; i < 3; i++) frame(12'h924, 1'b1, 1'b1);
    chk("R8 restart lb", int'(lb), 0);
    chk("R8 restart rai", int'(rai), 0);
    chk("R8 restart rsv", int'(rsv), 0);

    // R9 no advance without strobe
    clr();
    for (int i = 0; i < 4; i++) frame(put(4, 3'b100), 1'b0, 1'b1);
    @(negedge clk);
    cb = put(4, 3'b100); xb = 1'b1; rb = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 no strobe lb", int'(lb), 0);
    chk("R9 no strobe rsv", int'(rsv), 1);
    frame(put(4, 3'b100), 1'b1, 1'b1);
    chk("R9 strobe lb", int'(lb), 8);
    chk("R9 strobe rai", int'(rai), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule